// File: doc/BRIEF.md
# Interval Timer with Single-Address Compare

This block is a per-core interval timer. A counter starts at zero when reset is released and then advances by one on every clock. A 32-bit compare register shares one bus address with the counter. A read at that address returns the counter. A write at that address loads the compare register and leaves the counter as it was.

When the low 32 bits of the counter equal the compare value exactly, a sticky pending flag is set. The interrupt output is that flag gated by an enable input. Software clears the flag with an acknowledge pulse. Equality is the only trigger. If a compare value is written after the counter has already passed it, that value fires only once the low 32 bits wrap back around to it.

Each instance runs on its own and has no link to other instances. The register interface is a plain strobe bus, and every access completes in one cycle with no back-pressure. A read returns its data one cycle after the strobe, marked by a valid pulse.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter is zero, the compare register holds all ones, the pending flag is clear, `irq` is low and `bus_rvalid` is low. No interrupt occurs in the cycles that follow while the compare value is untouched.
- R2: The counter increments by exactly 1 on every clock after reset. A read strobe at `REG_ADDR` on a clock edge returns, on the next cycle, the counter value held before that edge, on all `CNT_W` bits (32 or 64), with `bus_rvalid` high for that one cycle.
- R3: A write strobe at `REG_ADDR` loads `bus_wdata` into the compare register and does not disturb the counter.
- R4: When the low 32 bits of the counter equal the compare value, the pending flag is set on the following edge. With the enable high, `irq` is high from that point on.
- R5: `irq` equals the pending flag ANDed with `irq_enable`. While the enable is low, a match still sets the flag, and `irq` rises as soon as the enable goes high.
- R6: An `irq_ack` pulse clears the pending flag on the next edge. If a match happens in the same cycle as the acknowledge, the match wins and the flag stays set.
- R7: Writing the compare register does not clear a pending interrupt.
- R8: A compare value equal to or below the current low counter bits causes no interrupt until the counter wraps around to it.
- R9: Read or write strobes at any address other than `REG_ADDR` have no effect: no `bus_rvalid` pulse, and the compare register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, loaded into the compare register |
| bus_rdata | output | CNT_W | Counter value returned by a read |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` holds read data |
| irq_enable | input | 1 | Interrupt enable; when low, `irq` is masked |
| irq_ack | input | 1 | Clears the pending flag |
| irq | output | 1 | Interrupt request |

## Verification
If the counter drifts, skips a value or is disturbed by a write, the next read shows a value that differs from the bench's count of clock edges. A wrong counter also moves the rise of `irq` away from the exact cycle that follows the match. If the compare register is loaded wrongly, the fault shows at the next match: `irq` rises in the wrong cycle or never rises. If the pending flag misbehaves, `irq` fails to stay high until an acknowledge, or fails to clear one cycle after the acknowledge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CMP_W = 32;
  typedef logic [CMP_W-1:0] cmp_t;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count,
  output cmp_t             count_lo
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end

  generate
    if (CNT_W == CMP_W) begin : g_narrow
      assign count_lo = count;
    end else begin : g_wide
      assign count_lo = count[CMP_W-1:0];
    end
  endgenerate

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/itmr_compare.sv
module itmr_compare
  import itmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cmp_t load_val,
  input  cmp_t count_lo,
  output logic match
);
  cmp_t cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cmp_q <= '1;
    else if (load) cmp_q <= load_val;
  end

  assign match = (count_lo == cmp_q);

  // R3
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cmp_q == $past(load_val));
  // R9
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_q));
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic ack,
  input  logic enable,
  output logic irq
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n)     pending <= 1'b0;
    else if (match) pending <= 1'b1;
    else if (ack)   pending <= 1'b0;
  end

  assign irq = pending & enable;

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pending);
  // R6
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !match) |=> !pending);
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              irq_enable,
  input  logic              irq_ack,
  output logic              irq
);
  logic             hit, rd_hit, wr_hit, match;
  logic [CNT_W-1:0] count;
  cmp_t             count_lo;

  assign hit    = (bus_addr == REG_ADDR);
  assign rd_hit = hit & bus_rd;
  assign wr_hit = hit & bus_wr;

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count(count), .count_lo(count_lo)
  );

  itmr_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .load(wr_hit), .load_val(bus_wdata),
    .count_lo(count_lo), .match(match)
  );

  itmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .match(match), .ack(irq_ack),
    .enable(irq_enable), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      if (rd_hit) bus_rdata <= count;
    end
  end

  // R2
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> bus_rvalid && bus_rdata == $past(count));
  // R9
  rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !bus_rvalid);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CNT_W = 64;
  localparam logic [3:0] RA = 4'h2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, irq_enable = 1'b0, irq_ack = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [CNT_W-1:0] bus_rdata;
  logic bus_rvalid, irq;

  int nchk = 0, nfail = 0;
  bit done = 0;
  longint edges = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  interval_timer #(.CNT_W(CNT_W), .ADDR_W(4), .REG_ADDR(RA)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_enable(irq_enable), .irq_ack(irq_ack),
    .irq(irq)
  );

  task automatic check(string req, longint got, longint exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_read(logic [3:0] a, string req);
    longint exp;
    bus_addr = a; bus_rd = 1'b1; exp = edges;
    tick();
    bus_rd = 1'b0;
    if (a == RA) begin
      check(req, longint'(bus_rvalid), 1);
      check(req, longint'(bus_rdata), exp);
    end else begin
      check(req, longint'(bus_rvalid), 0);
    end
  endtask

  task automatic do_write(logic [3:0] a, longint v);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = v[31:0];
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    longint v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 irq", longint'(irq), 0);
    check("R1 rvalid", longint'(bus_rvalid), 0);
    check("R1 rdata", longint'(bus_rdata), 0);
    rst_n = 1'b1;
    irq_enable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      check("R1 no irq with reset compare", longint'(irq), 0);
    end
    // R2: read sweep with varying gaps
    for (int g = 0; g < 16; g++) begin
      repeat (g) tick();
      do_read(RA, "R2 read count");
      check("R2 rvalid one cycle", longint'(bus_rvalid), 1);
      tick();
      check("R2 rvalid drops", longint'(bus_rvalid), 0);
    end
    // R3/R4/R6: match sweep over distances
    for (int d = 1; d <= 30; d++) begin
      v = edges + d;
      do_write(RA, v);
      if (d > 3) do_read(RA, "R3 counter kept across write");
      while (edges < v) tick();
      check("R4 no irq before match", longint'(irq), 0);
      tick();
      check("R4 irq after match", longint'(irq), 1);
      tick();
      check("R4 irq sticky", longint'(irq), 1);
      ack_pulse();
      check("R6 ack clears", longint'(irq), 0);
    end
    // R6: match and ack in same cycle
    v = edges + 6;
    do_write(RA, v);
    while (edges < v) tick();
    ack_pulse();
    check("R6 match beats ack", longint'(irq), 1);
    ack_pulse();
    check("R6 later ack clears", longint'(irq), 0);
    // R5: masked match stays pending
    irq_enable = 1'b0;
    v = edges + 5;
    do_write(RA, v);
    repeat (10) begin
      tick();
      check("R5 masked irq low", longint'(irq), 0);
    end
    irq_enable = 1'b1;
    #1;
    check("R5 unmask shows pending", longint'(irq), 1);
    // R7: compare write keeps pending
    do_write(RA, edges + 5000);
    check("R7 pending kept after write", longint'(irq), 1);
    tick();
    check("R7 pending still kept", longint'(irq), 1);
    ack_pulse();
    check("R7 ack clears", longint'(irq), 0);
    // R8: compare already passed
    for (int p = 0; p < 6; p++) begin
      v = edges - p;
      do_write(RA, v);
      for (int k = 0; k < 25; k++) begin
        tick();
        check("R8 passed compare silent", longint'(irq), 0);
      end
    end
    // R9: accesses off REG_ADDR
    do_write(RA, edges + 3000);
    for (int a = 0; a < 16; a++) begin
      if (a[3:0] == RA) continue;
      do_write(a[3:0], edges + 4);
      for (int k = 0; k < 8; k++) begin
        tick();
        check("R9 foreign write ignored", longint'(irq), 0);
      end
      do_read(a[3:0], "R9 foreign read no rvalid");
    end
    do_read(RA, "R2 final read");
    finish_run();
  end
endmodule